// File: doc/BRIEF.md
# Floating-Point Operand Conditioner

This block sits in front of an arithmetic datapath. It takes up to three source operands, called A, B and C, and prepares them in one registered stage. Each operand is a 64-bit word with its own precision select: single or double. A shared flush-mode input chooses how subnormal operands are treated.

With flush mode low, every subnormal operand is normalized. The result has a hidden leading one, a left-aligned fraction and a signed exponent two bits wider than the format exponent. With flush mode high, every subnormal operand becomes a zero that keeps its sign, so the datapath never receives a subnormal. Operands that are already normal, zero or infinite pass through unchanged.

The block also reports two conditions through an operand-use mask:
- `out_nan` is raised when any used operand is a NaN, meaning the operation's result must be a quiet NaN.
- `out_invalid` is raised when any used operand is a signaling NaN.

Choosing which NaN wins is left to the datapath.

Top module: `fpop_precond`

## Requirements
- R1: `out_valid` equals `in_valid` from one clock earlier. Result fields and flags are registered on a cycle with `in_valid` high. Synchronous reset clears `out_valid`.
- R2: Operand layout depends on precision.
  - When `prec_dbl[i]`=1, the operand is double: sign bit 63, exponent bits 62:52, fraction bits 51:0.
  - When `prec_dbl[i]`=0, the operand is single: sign bit 31, exponent bits 30:23, fraction bits 22:0. Bits 63:32 are ignored.
  - The output sign always equals the input sign.
- R3: Operands that are not subnormal keep their biased exponent, zero-extended to 13 bits, and their fraction. A single fraction is returned in bits 22:0, with the upper bits zero. The class codes are: 0 zero, 1 normal, 2 infinity, 3 quiet NaN, 4 signaling NaN. A zero has exponent 0 and fraction 0.
- R4: With `flush_mode`=0, a subnormal operand (exponent field 0, fraction nonzero) leaves as class 1. Let L be the count of leading zeros in its fraction field. Its exponent is −L in 13-bit two's complement. Its fraction is the input fraction shifted left by L+1, truncated to the format's fraction width.
- R5: With `flush_mode`=1, a subnormal operand leaves as class 0 with exponent 0, fraction 0 and its sign kept. No output exponent is negative in this mode.
- R6: Each operand is conditioned independently. Any mix of classes and precisions on A, B and C yields, for each operand, the result it would get alone.
- R7: `out_nan` is 1 when any used operand has an all-ones exponent and a nonzero fraction. A fraction MSB of 1 marks a quiet NaN and 0 marks a signaling NaN. Both kinds raise `out_nan`.
- R8: `out_invalid` is 1 exactly when any used operand is a signaling NaN. A quiet NaN alone does not raise it.
- R9: An operand whose `opd_use` bit is 0 has no effect on `out_nan` or `out_invalid`. Its data fields are still conditioned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands present this cycle |
| flush_mode | input | 1 | 1: flush subnormals to zero; 0: normalize them |
| opd_in | input | 3x64 | Raw operands; index 0 is A, 1 is B, 2 is C |
| prec_dbl | input | 3 | Per-operand precision, 1 = double |
| opd_use | input | 3 | Per-operand use mask for the NaN flags |
| out_valid | output | 1 | Results present |
| res_sign | output | 3 | Conditioned signs |
| res_exp | output | 3x13 | Widened signed exponents |
| res_frac | output | 3x52 | Conditioned fractions, without the hidden bit |
| res_cls | output | 3x3 | Class code per operand |
| out_nan | output | 1 | Result must be a quiet NaN |
| out_invalid | output | 1 | A used operand is a signaling NaN |

## Verification
The assertions assume three things:
- `flush_mode`, `opd_use` and `prec_dbl` are meaningful only on cycles with `in_valid` high.
- The 64-bit operand already follows the layout its precision bit selects.
- For single operands, nothing in bits 63:32 is relied on.

The stimulus builds every operand from a class, a precision and a sign, and places deliberate garbage in the upper word of single operands. It holds all inputs steady from one falling edge to the next, so each capture sees one coherent vector.

// File: rtl/fpop_pkg.sv
package fpop_pkg;

    localparam int DATA_W  = 64;
    localparam int FRAC_W  = 52;
    localparam int EXP_D   = 11;
    localparam int S_FRAC  = 23;
    localparam int S_EXP   = 8;
    localparam int XEXP_W  = EXP_D + 2;
    localparam int LZ_W    = $clog2(FRAC_W + 1);
    localparam int S_PAD   = FRAC_W - S_FRAC;

    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_NORM = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } opcls_e;

    typedef struct packed {
        opcls_e                 cls;
        logic                   sign;
        logic [XEXP_W-1:0]      xexp;
        logic [FRAC_W-1:0]      frac;
    } opd_s;

    function automatic logic cls_is_nan(opcls_e c);
        return (c == CLS_QNAN) || (c == CLS_SNAN);
    endfunction

    function automatic logic [FRAC_W-1:0] frac_mask(logic is_dbl);
        return is_dbl ? {FRAC_W{1'b1}} : {{S_PAD{1'b0}}, {S_FRAC{1'b1}}};
    endfunction

endpackage

// File: rtl/fpop_lzc.sv
module fpop_lzc #(
    parameter int W  = 52,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) cnt = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/fpop_opd_cond.sv
module fpop_opd_cond
    import fpop_pkg::*;
(
    input  logic [DATA_W-1:0] raw,
    input  logic              is_dbl,
    input  logic              flush,
    output opd_s              res
);
    logic              sgn;
    logic [EXP_D-1:0]  efld;
    logic [FRAC_W-1:0] ffld;
    logic              e_ones;
    logic              qbit;
    logic [LZ_W-1:0]   lz_raw;
    logic [LZ_W-1:0]   lz_fmt;
    logic [LZ_W-1:0]   shamt;
    logic [FRAC_W-1:0] nfrac;

    always_comb begin
        if (is_dbl) begin
            sgn    = raw[FRAC_W + EXP_D];
            efld   = raw[FRAC_W + EXP_D - 1 : FRAC_W];
            ffld   = raw[FRAC_W-1:0];
            e_ones = &raw[FRAC_W + EXP_D - 1 : FRAC_W];
            qbit   = raw[FRAC_W-1];
        end else begin
            sgn    = raw[S_FRAC + S_EXP];
            efld   = {{(EXP_D - S_EXP){1'b0}}, raw[S_FRAC + S_EXP - 1 : S_FRAC]};
            ffld   = {{S_PAD{1'b0}}, raw[S_FRAC-1:0]};
            e_ones = &raw[S_FRAC + S_EXP - 1 : S_FRAC];
            qbit   = raw[S_FRAC-1];
        end
    end

    fpop_lzc #(.W(FRAC_W), .CW(LZ_W)) u_lzc (
        .vec (ffld),
        .cnt (lz_raw)
    );

    always_comb begin
        lz_fmt = is_dbl ? lz_raw : lz_raw - LZ_W'(S_PAD);
        shamt  = lz_fmt + LZ_W'(1);
        nfrac  = (ffld << shamt) & frac_mask(is_dbl);
    end

    always_comb begin
        res.sign = sgn;
        res.xexp = {{(XEXP_W - EXP_D){1'b0}}, efld};
        res.frac = ffld;
        res.cls  = CLS_NORM;
        if (efld == '0) begin
            if (ffld == '0 || flush) begin
                res.cls  = CLS_ZERO;
                res.xexp = '0;
                res.frac = '0;
            end else begin
                res.xexp = XEXP_W'(0) - XEXP_W'(lz_fmt);
                res.frac = nfrac;
            end
        end else if (e_ones) begin
            if (ffld == '0)  res.cls = CLS_INF;
            else if (qbit)   res.cls = CLS_QNAN;
            else             res.cls = CLS_SNAN;
        end
    end
endmodule

// File: rtl/fpop_precond.sv
module fpop_precond
    import fpop_pkg::*;
#(
    parameter int N_OPD = 3
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                in_valid,
    input  logic                                flush_mode,
    input  logic [N_OPD-1:0][DATA_W-1:0]        opd_in,
    input  logic [N_OPD-1:0]                    prec_dbl,
    input  logic [N_OPD-1:0]                    opd_use,
    output logic                                out_valid,
    output logic [N_OPD-1:0]                    res_sign,
    output logic [N_OPD-1:0][XEXP_W-1:0]        res_exp,
    output logic [N_OPD-1:0][FRAC_W-1:0]        res_frac,
    output logic [N_OPD-1:0][2:0]               res_cls,
    output logic                                out_nan,
    output logic                                out_invalid
);
    opd_s [N_OPD-1:0] cond_c;
    opd_s [N_OPD-1:0] cond_q;
    logic             nan_c;
    logic             inv_c;
    logic             vld_q;
    logic             nan_q;
    logic             inv_q;

    for (genvar g = 0; g < N_OPD; g++) begin : g_opd
        fpop_opd_cond u_cond (
            .raw    (opd_in[g]),
            .is_dbl (prec_dbl[g]),
            .flush  (flush_mode),
            .res    (cond_c[g])
        );
        assign res_sign[g] = cond_q[g].sign;
        assign res_exp[g]  = cond_q[g].xexp;
        assign res_frac[g] = cond_q[g].frac;
        assign res_cls[g]  = cond_q[g].cls;

        // R5
        flush_no_neg_exp_chk: assert property (@(posedge clk) disable iff (rst)
            in_valid && flush_mode |=> !res_exp[g][XEXP_W-1]);

        // R3
        zero_cls_clean_chk: assert property (@(posedge clk) disable iff (rst)
            out_valid && res_cls[g] == 3'(CLS_ZERO) |-> res_exp[g] == '0 && res_frac[g] == '0);
    end

    always_comb begin
        nan_c = 1'b0;
        inv_c = 1'b0;
        for (int i = 0; i < N_OPD; i++) begin
            if (opd_use[i] && cls_is_nan(cond_c[i].cls)) nan_c = 1'b1;
            if (opd_use[i] && cond_c[i].cls == CLS_SNAN)  inv_c = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            nan_q  <= 1'b0;
            inv_q  <= 1'b0;
            cond_q <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                cond_q <= cond_c;
                nan_q  <= nan_c;
                inv_q  <= inv_c;
            end
        end
    end

    assign out_valid   = vld_q;
    assign out_nan     = nan_q;
    assign out_invalid = inv_q;

    // R1
    valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R1
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R8
    invalid_implies_nan_chk: assert property (@(posedge clk) disable iff (rst)
        out_invalid |-> out_nan);
    // R9
    unused_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && opd_use == '0 |=> !out_nan && !out_invalid);
endmodule

// File: tb/tb_fpop_precond.sv
module tb_fpop_precond;
    localparam int CLK_PERIOD = 10;
    localparam int NOP = 3;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 in_valid;
    logic                 flush_mode;
    logic [NOP-1:0][63:0] opd_in;
    logic [NOP-1:0]       prec_dbl;
    logic [NOP-1:0]       opd_use;
    logic                 out_valid;
    logic [NOP-1:0]       res_sign;
    logic [NOP-1:0][12:0] res_exp;
    logic [NOP-1:0][51:0] res_frac;
    logic [NOP-1:0][2:0]  res_cls;
    logic                 out_nan;
    logic                 out_invalid;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpop_precond #(.N_OPD(NOP)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .flush_mode(flush_mode),
        .opd_in(opd_in), .prec_dbl(prec_dbl), .opd_use(opd_use),
        .out_valid(out_valid), .res_sign(res_sign), .res_exp(res_exp),
        .res_frac(res_frac), .res_cls(res_cls), .out_nan(out_nan),
        .out_invalid(out_invalid)
    );

    typedef struct {
        int          cls;
        bit          sgn;
        logic [12:0] xexp;
        logic [51:0] frac;
    } exp_t;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // class 0 zero, 1 normal, 2 subnormal, 3 inf, 4 qnan, 5 snan
    function automatic logic [63:0] mk(int k, bit dbl, bit s, int seed);
        int fw = dbl ? 52 : 23;
        int ew = dbl ? 11 : 8;
        logic [63:0] emax = (64'd1 << ew) - 1;
        logic [63:0] fmask = (64'd1 << fw) - 1;
        logic [63:0] e = 0;
        logic [63:0] f = 0;
        logic [63:0] v;
        case (k)
            1: begin e = 64'(1 + seed % 200); f = (64'h9E37_79B9_7F4A_7C15 >> seed[3:0]) & fmask; end
            2: begin e = 0; f = ((64'h0000_0123_4567_89AB << seed[4:0]) & fmask) | 64'd1; end
            3: begin e = emax; f = 0; end
            4: begin e = emax; f = (64'd1 << (fw-1)) | 64'(seed); end
            5: begin e = emax; f = 64'(seed + 1) & (fmask >> 1); end
            default: begin e = 0; f = 0; end
        endcase
        v = (64'(s) << (fw + ew)) | (e << fw) | f;
        if (!dbl) v = v | 64'hA5A5_5A5A_0000_0000;
        return v;
    endfunction

    function automatic exp_t ref_cond(logic [63:0] raw, bit dbl, bit fl);
        exp_t r;
        int fw = dbl ? 52 : 23;
        int ew = dbl ? 11 : 8;
        logic [63:0] fmask = (64'd1 << fw) - 1;
        logic [63:0] emax = (64'd1 << ew) - 1;
        logic [63:0] f = raw & fmask;
        logic [63:0] e = (raw >> fw) & emax;
        int p = 0;
        r.sgn = raw[fw + ew];
        r.xexp = 13'(e);
        r.frac = 52'(f);
        r.cls = 1;
        if (e == 0) begin
            if (f == 0 || fl) begin
                r.cls = 0; r.xexp = 0; r.frac = 0;
            end else begin
                for (int i = 0; i < fw; i++) if (f[i]) p = i;
                r.xexp = 13'(p - (fw - 1));
                r.frac = 52'((f << (fw - p)) & fmask);
            end
        end else if (e == emax) begin
            if (f == 0) r.cls = 2;
            else if (f[fw-1]) r.cls = 3;
            else r.cls = 4;
        end
        return r;
    endfunction

    task automatic run_vec(input logic [NOP-1:0][63:0] ops, input logic [NOP-1:0] pd,
                           input logic [NOP-1:0] use_m, input bit fl, input string tag);
        exp_t e;
        bit xn = 0;
        bit xi = 0;
        string rq;
        in_valid = 1; flush_mode = fl; opd_in = ops; prec_dbl = pd; opd_use = use_m;
        @(posedge clk);
        @(negedge clk);
        in_valid = 0;
        chk(out_valid == 1'b1, "R1 valid", 64'(out_valid), 64'd1);
        for (int i = 0; i < NOP; i++) begin
            bit sub;
            e = ref_cond(ops[i], pd[i], fl);
            sub = (((ops[i] >> (pd[i] ? 52 : 23)) & (pd[i] ? 64'h7FF : 64'hFF)) == 0) &&
                  ((ops[i] & (pd[i] ? 64'hF_FFFF_FFFF_FFFF : 64'h7F_FFFF)) != 0);
            rq = sub ? (fl ? "R5" : "R4") : "R3";
            chk(res_sign[i] == e.sgn, {"R2 sign ", tag}, 64'(res_sign[i]), 64'(e.sgn));
            chk(res_cls[i] == 3'(e.cls), {rq, " cls ", tag}, 64'(res_cls[i]), 64'(e.cls));
            chk(res_exp[i] == e.xexp, {rq, " exp ", tag}, 64'(res_exp[i]), 64'(e.xexp));
            chk(res_frac[i] == e.frac, {rq, " frac ", tag}, 64'(res_frac[i]), 64'(e.frac));
            if (use_m[i] && (e.cls == 3 || e.cls == 4)) xn = 1;
            if (use_m[i] && e.cls == 4) xi = 1;
        end
        rq = (use_m != 3'b111) ? "R9" : "R7";
        chk(out_nan == xn, {rq, " nan ", tag}, 64'(out_nan), 64'(xn));
        rq = (use_m != 3'b111) ? "R9" : "R8";
        chk(out_invalid == xi, {rq, " invalid ", tag}, 64'(out_invalid), 64'(xi));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [NOP-1:0][63:0] ops;
        rst = 1; in_valid = 0; flush_mode = 0; opd_in = '0; prec_dbl = '0; opd_use = '0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 reset", 64'(out_valid), 64'd0);
        rst = 0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 idle", 64'(out_valid), 64'd0);

        // R4 / R5: subnormal leading-bit sweep in both precisions and modes
        for (int fl = 0; fl < 2; fl++) begin
            for (int d = 0; d < 2; d++) begin
                int fw = d ? 52 : 23;
                int ew = d ? 11 : 8;
                for (int p = 0; p < fw; p++) begin
                    logic [63:0] f = (64'd1 << p) | (p > 1 ? 64'd2 : 64'd0);
                    ops[0] = (64'(p & 1) << (fw + ew)) | f;
                    if (d == 0) ops[0] = ops[0] | 64'hFFFF_0000_0000_0000;
                    ops[1] = mk(1, d[0], 1'b0, p);
                    ops[2] = mk(0, d[0], 1'b1, p);
                    run_vec(ops, {3{d[0]}}, 3'b111, fl[0], "sweep");
                end
            end
        end

        // R6 / R7 / R8 / R9: class cube over three operands, mixed precision and use mask
        for (int fl = 0; fl < 2; fl++) begin
            for (int ka = 0; ka < 6; ka++) begin
                for (int kb = 0; kb < 6; kb++) begin
                    for (int kc = 0; kc < 6; kc++) begin
                        for (int um = 0; um < 8; um++) begin
                            int sd = ka * 37 + kb * 11 + kc * 5 + um;
                            logic [2:0] pd = 3'(sd);
                            ops[0] = mk(ka, pd[0], sd[0], sd);
                            ops[1] = mk(kb, pd[1], sd[1], sd + 3);
                            ops[2] = mk(kc, pd[2], sd[2], sd + 7);
                            run_vec(ops, pd, 3'(um), fl[0], "R6 cube");
                        end
                    end
                end
            end
        end

        @(negedge clk);
        chk(out_valid == 1'b0, "R1 drop", 64'(out_valid), 64'd0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule